// File: doc/BRIEF.md
# Third-order recursive fixed-point filter

This block runs a third-order all-pole recursive filter on a stream of signed integer samples. Each time `in_valid` is high, the sample on `in_data` is placed inside a 16-bit two's-complement working word. The three previous results, each weighted by its own feedback coefficient, are subtracted from it. The difference is the new result: it is shifted into a three-deep history chain and appears on `out_data` one cycle later, together with a one-cycle `out_valid` pulse. The input itself enters with a weight of one.

The position of the sample in the word is fixed by a guard budget. Two sign-extension bits above the sample absorb a worst-case gain of four from the input to any node. Three zero bits below it hold the quantization error for a summed error gain of eight. That leaves eleven bits for the sample. An 8-bit input fits entirely and leaves spare sign bits at the top. A 12-bit input loses its least significant bit. Every coefficient has seven bits: a sign bit and six fraction bits. All products are truncated back to the word, and nothing is rounded or saturated.

Top module: `iir3_filter`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0, and all three history registers hold zero. After `rst_n` rises, the block ignores `in_valid` for two clock cycles while its internal reset is released.
- R2: With `IN_W` = 8, the sample enters the word as its sign-extended value times 8: bits 2..0 are zero and bits 15..11 copy the sample's sign. For example, 127 becomes 1016 and -128 becomes -1024.
- R3: With `IN_W` = 12, the sample is first shifted right arithmetically by one, which rounds it toward minus infinity, and the result is then multiplied by 8. For example, 2047 becomes 8184 and -1 becomes -8.
- R4: `out_valid` is high for exactly the cycle that follows each cycle in which `in_valid` is high. Back-to-back strobes give back-to-back pulses.
- R5: Each feedback product is the full product of the coefficient and the history word, divided by 64 with the quotient rounded toward minus infinity, and then reduced to 16 bits. For example, a coefficient of 1 times a history value of -8 gives -1.
- R6: The new result is w = placed input - p1 - p2 - p3. Here p1 comes from `fb_k1` and the newest history value, p2 from `fb_k2` and the one before it, and p3 from `fb_k3` and the oldest. On each strobe the history shifts by one place: w becomes the newest value and the oldest is dropped.
- R7: All sums and differences wrap modulo 2^16 with no saturation.
- R8: When `in_valid` is low, neither `out_data` nor the history changes, whatever `in_data` and the coefficients do.
- R9: Each coefficient port carries a signed 7-bit value k that stands for k/64. The full range from -64 to 63 is accepted, so -64 means a gain of minus one.
- R10: `out_data` shows the newest history value, which is the most recent w.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Sample strobe |
| in_data | input | IN_W | Signed input sample (IN_W is 8 or 12) |
| fb_k1 | input | 7 | Signed weight of the newest history value, in units of 1/64 |
| fb_k2 | input | 7 | Signed weight of the middle history value, in units of 1/64 |
| fb_k3 | input | 7 | Signed weight of the oldest history value, in units of 1/64 |
| out_valid | output | 1 | One-cycle pulse one cycle after each strobe |
| out_data | output | 16 | Newest filter result |

## Verification
The assertions assume that `in_valid` stays low for the two cycles after `rst_n` rises, while the internal reset is still held. The bench keeps that rule: after each reset it waits three cycles before it sends a sample. The placement property needs an all-zero history, and it applies only when the history really is zero. The truncation properties compare each product with its coefficient and history word modulo 2^22, so wrapped products at the extreme coefficient values stay inside what they accept. The bench varies the coefficients only while `in_valid` is low, or holds them steady across a strobe, so every result it checks follows from known weights.

// File: rtl/iir3_pkg.sv
`timescale 1ns/1ps
package iir3_pkg;
  localparam int WORD_W    = 16;
  localparam int COEF_W    = 7;
  localparam int COEF_FRAC = COEF_W - 1;
  localparam int GUARD_HI  = 2;
  localparam int GUARD_LO  = 3;
  localparam int TAPS      = 3;
  localparam int SLOT_W    = WORD_W - GUARD_HI - GUARD_LO;
  localparam int PROD_W    = WORD_W + COEF_W;

  typedef logic signed [WORD_W-1:0] node_t;
  typedef logic signed [COEF_W-1:0] coef_t;
endpackage

// File: rtl/iir3_rst_sync.sv
`timescale 1ns/1ps
module iir3_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/iir3_place.sv
`timescale 1ns/1ps
module iir3_place import iir3_pkg::*; #(
  parameter int IN_W = 8
) (
  input  logic signed [IN_W-1:0] in_data,
  output node_t                  placed
);
  // samples wider than the free slot lose their low bits (floor)
  localparam int DROP = (IN_W > SLOT_W) ? (IN_W - SLOT_W) : 0;

  always_comb begin
    placed = node_t'(in_data >>> DROP) <<< GUARD_LO;
  end
endmodule

// File: rtl/iir3_tap.sv
`timescale 1ns/1ps
module iir3_tap import iir3_pkg::*; (
  input  coef_t k,
  input  node_t d,
  output node_t p
);
  logic signed [PROD_W-1:0] full;

  always_comb begin
    full = k * d;
    // arithmetic shift drops the fraction: rounds toward minus infinity
    p = node_t'(full >>> COEF_FRAC);
  end
endmodule

// File: rtl/iir3_filter.sv
`timescale 1ns/1ps
module iir3_filter import iir3_pkg::*; #(
  parameter int IN_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [IN_W-1:0]   in_data,
  input  logic signed [COEF_W-1:0] fb_k1,
  input  logic signed [COEF_W-1:0] fb_k2,
  input  logic signed [COEF_W-1:0] fb_k3,
  output logic                     out_valid,
  output logic signed [WORD_W-1:0] out_data
);
  logic  rst_core_n;
  coef_t coef  [TAPS];
  node_t dly_q [TAPS];
  node_t dly_d [TAPS];
  node_t prod  [TAPS];
  node_t placed;
  node_t acc;
  logic  vld_q;
  logic  vld_d;

  iir3_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  iir3_place #(.IN_W(IN_W)) u_place (
    .in_data (in_data),
    .placed  (placed)
  );

  assign coef[0] = fb_k1;
  assign coef[1] = fb_k2;
  assign coef[2] = fb_k3;

  generate
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      iir3_tap u_tap (
        .k (coef[t]),
        .d (dly_q[t]),
        .p (prod[t])
      );
    end
  endgenerate

  // feedback sum, wraps in the 16-bit word
  always_comb begin
    acc = placed;
    for (int i = 0; i < TAPS; i++) begin
      acc = acc - prod[i];
    end
  end

  // next state of the history chain and strobe
  always_comb begin
    vld_d    = in_valid;
    dly_d[0] = acc;
    for (int i = 1; i < TAPS; i++) begin
      dly_d[i] = dly_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      for (int i = 0; i < TAPS; i++) begin
        dly_q[i] <= '0;
      end
    end else if (in_valid) begin
      for (int i = 0; i < TAPS; i++) begin
        dly_q[i] <= dly_d[i];
      end
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dly_q[0];
endmodule

// File: rtl/iir3_filter_chk.sv
`timescale 1ns/1ps
module iir3_filter_chk import iir3_pkg::*; #(
  parameter int IN_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic signed [IN_W-1:0] in_data,
  input coef_t                  k1,
  input coef_t                  k2,
  input coef_t                  k3,
  input node_t                  d1,
  input node_t                  d2,
  input node_t                  d3,
  input node_t                  p1,
  input node_t                  p2,
  input node_t                  p3,
  input logic                   out_valid,
  input node_t                  out_data
);
  localparam int DROP = (IN_W > SLOT_W) ? (IN_W - SLOT_W) : 0;
  localparam int MULT = 1 << (GUARD_LO - DROP);

  node_t exp_place;

  generate
    if (DROP > 0) begin : g_drop
      always_comb exp_place = (node_t'(in_data) - node_t'(in_data[DROP-1:0])) * node_t'(MULT);
    end else begin : g_keep
      always_comb exp_place = node_t'(in_data) * node_t'(MULT);
    end
  endgenerate

  function automatic logic [PROD_W-2:0] trunc_rem(coef_t k, node_t d, node_t p);
    logic signed [PROD_W-2:0] full;
    full = k * d;
    return full - {p, {COEF_FRAC{1'b0}}};
  endfunction

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_data == '0 && d2 == '0 && d3 == '0));

  a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2 and R3: empty history leaves just the placed sample
  a_r2_place: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && d1 == '0 && d2 == '0 && d3 == '0) |=> out_data == $past(exp_place));

  a_r6_chain: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (d2 == $past(d1) && d3 == $past(d2)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(d2) && $stable(d3)));

  a_r5_trunc_t1: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_rem(k1, d1, p1) < (1 << COEF_FRAC));
  a_r5_trunc_t2: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_rem(k2, d2, p2) < (1 << COEF_FRAC));
  a_r5_trunc_t3: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_rem(k3, d3, p3) < (1 << COEF_FRAC));
endmodule

bind iir3_filter iir3_filter_chk #(.IN_W(IN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .k1        (fb_k1),
  .k2        (fb_k2),
  .k3        (fb_k3),
  .d1        (dly_q[0]),
  .d2        (dly_q[1]),
  .d3        (dly_q[2]),
  .p1        (prod[0]),
  .p2        (prod[1]),
  .p3        (prod[2]),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/iir3_filter_test.sv
`timescale 1ns/1ps
module iir3_filter_test;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [7:0]  din8;
  logic signed [11:0] din12;
  logic signed [6:0]  k1, k2, k3;
  logic               ov8, ov12;
  logic signed [15:0] out8, out12;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;
  int st [2][3];

  always #2.5 clk = ~clk;

  iir3_filter #(.IN_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(din8),
    .fb_k1(k1), .fb_k2(k2), .fb_k3(k3), .out_valid(ov8), .out_data(out8)
  );

  iir3_filter #(.IN_W(12)) uut12 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(din12),
    .fb_k1(k1), .fb_k2(k2), .fb_k3(k3), .out_valid(ov12), .out_data(out12)
  );

  function automatic int floordiv(int n, int d);
    int q;
    q = n / d;
    if ((n % d) != 0 && (n < 0)) q = q - 1;
    return q;
  endfunction

  function automatic int wrap16(int v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  // reference step for one channel (0: 8-bit, 1: 12-bit)
  function automatic int step(int ch, int x);
    int pl, w;
    pl = (ch == 0) ? x * 8 : floordiv(x, 2) * 8;
    w = pl - floordiv(int'(k1) * st[ch][0], 64)
           - floordiv(int'(k2) * st[ch][1], 64)
           - floordiv(int'(k3) * st[ch][2], 64);
    w = wrap16(w);
    st[ch][2] = st[ch][1];
    st[ch][1] = st[ch][0];
    st[ch][0] = w;
    return w;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    for (int c = 0; c < 2; c++) for (int i = 0; i < 3; i++) st[c][i] = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input int x8, input int x12, input string tag8, input string tag12);
    int e8, e12;
    in_valid = 1'b1;
    din8  = x8[7:0];
    din12 = x12[11:0];
    @(negedge clk);
    e8  = step(0, x8);
    e12 = step(1, x12);
    chk({tag8, " data8"}, int'(out8), e8);
    chk({tag12, " data12"}, int'(out12), e12);
    chk("R4 valid8 pulse", int'(ov8), 1);
    chk("R4 valid12 pulse", int'(ov12), 1);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1 reset valid8", int'(ov8), 0);
    chk("R1 reset data8", int'(out8), 0);
    chk("R1 reset valid12", int'(ov12), 0);
    chk("R1 reset data12", int'(out12), 0);
    do_reset();
    chk("R1 after release data8", int'(out8), 0);
    chk("R1 after release valid12", int'(ov12), 0);
  endtask

  task automatic t_place();
    do_reset();
    k1 = 0; k2 = 0; k3 = 0;
    send(127, 2047, "R2 max", "R3 max");
    chk("R2 literal 127", int'(out8), 1016);
    chk("R3 literal 2047", int'(out12), 8184);
    send(-128, -2048, "R2 min", "R3 min");
    chk("R2 literal -128", int'(out8), -1024);
    send(-1, -1, "R2 minus one", "R3 minus one");
    chk("R3 literal -1 floors", int'(out12), -8);
    send(5, 5, "R2 small", "R3 odd");
    chk("R3 literal 5", int'(out12), 16);
  endtask

  task automatic t_pulse();
    do_reset();
    k1 = 7'sd10; k2 = 0; k3 = 0;
    send(3, 9, "R4 single", "R4 single");
    @(negedge clk);
    chk("R4 pulse ends8", int'(ov8), 0);
    chk("R4 pulse ends12", int'(ov12), 0);
  endtask

  task automatic t_trunc();
    do_reset();
    k1 = 7'sd1; k2 = 0; k3 = 0;
    send(-1, -1, "R5 seed", "R5 seed");
    send(0, 0, "R5 neg floor", "R5 neg floor");
    chk("R5 floor toward minus inf", int'(out8), 1);
    do_reset();
    send(1, 2, "R5 seed pos", "R5 seed pos");
    send(0, 0, "R5 pos floor", "R5 pos floor");
    chk("R5 positive truncation", int'(out8), 0);
  endtask

  task automatic t_recur();
    do_reset();
    k1 = 7'sd52; k2 = -7'sd20; k3 = 7'sd9;
    send(100, 1500, "R6 impulse", "R6 impulse");
    for (int i = 0; i < 12; i++) send(0, 0, "R6 ring", "R6 ring");
    for (int i = 0; i < 8; i++) send(i * 13 - 50, i * 301 - 1000, "R6 mixed", "R6 mixed");
    do_reset();
    k1 = 7'sd63; k2 = -7'sd64; k3 = 7'sd63;
    for (int i = 0; i < 10; i++) send((i % 3) * 40 - 40, (i % 4) * 500 - 700, "R9 extreme", "R9 extreme");
  endtask

  task automatic t_wrap();
    do_reset();
    k1 = -7'sd64; k2 = 0; k3 = 0;
    for (int i = 0; i < 40; i++) begin
      send(127, 2047, "R7 accumulate", "R7 accumulate");
      if (i == 32) chk("R7 wraps negative", int'(out8), -32008);
    end
  endtask

  task automatic t_hold();
    int keep8, keep12;
    do_reset();
    k1 = -7'sd30; k2 = 7'sd17; k3 = -7'sd5;
    send(60, 900, "R8 prime", "R8 prime");
    send(-20, -300, "R8 prime", "R8 prime");
    keep8 = int'(out8);
    keep12 = int'(out12);
    for (int i = 0; i < 5; i++) begin
      din8 = 8'(i * 37); din12 = 12'(i * 411);
      k1 = 7'(i * 11); k2 = 7'(-i * 7); k3 = 7'(i * 5);
      @(negedge clk);
      chk("R8 idle data8", int'(out8), keep8);
      chk("R8 idle data12", int'(out12), keep12);
      chk("R4 idle valid8", int'(ov8), 0);
    end
    k1 = -7'sd30; k2 = 7'sd17; k3 = -7'sd5;
    send(7, 70, "R8 state kept", "R8 state kept");
    send(0, 0, "R10 newest", "R10 newest");
  endtask

  initial begin
    rst_n = 1'b1;
    in_valid = 1'b0;
    din8 = '0; din12 = '0;
    k1 = '0; k2 = '0; k3 = '0;
    #1;
    t_reset();
    t_place();
    t_pulse();
    t_trunc();
    t_recur();
    t_wrap();
    t_hold();
    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL R4 watchdog act=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule